// File: doc/BRIEF.md
# Predicated Execute Stage with Gated Flag Updates

This block is the execute stage of a small load/store core that replaces short forward branches with conditional execution. Each issued operation carries an ALU opcode, two operands, a destination register index, a 4-bit condition code and a flag-update bit. The condition is tested against the stored condition flags. If it holds, the ALU result is written back and, if the flag-update bit is set, the flags are replaced. If it fails, the operation leaves no trace: no write-back and no flag change.

The flag-update bit is separate from the opcode. A single comparison can therefore steer a long run of later operations that compute without touching the flags. The stage has one registered cycle of latency. A flag change made by one operation is already seen by the condition test of the operation issued in the next cycle. The register file, fetch and memory access sit outside the block.

Top module: `pred_exec_unit`

## Requirements
- R1: While reset is asserted, and after it is released, `wb_en` is 0 and `flags_o` is 0000. The flag bit order is {N,Z,C,V}, with N at bit 3 and V at bit 0.
- R2: Condition codes:
  - 0: always.
  - 1: Z=1.
  - 2: Z=0.
  - 3: C=1.
  - 4: C=0.
  - 5: V=1.
  - 6: V=0.
  - 7: C=1 and V=0.

  An operation executes only when its condition holds against the flags present in its issue cycle.
- R3: An issued operation whose condition fails produces `wb_en`=0 and leaves every flag unchanged, even when its flag-update bit is set.
- R4: An executed operation with the flag-update bit clear writes its result and leaves every flag unchanged.
- R5: Opcode 0 is add and opcode 1 is subtract (a-b). For both, N is the result MSB and Z is set when the result is zero. For add, C is the unsigned carry-out. For subtract, C is not-borrow (a >= b unsigned). V is signed overflow.
- R6: Opcodes 2 to 7 are the logic and move operations:
  - 2: a AND b.
  - 3: a OR b.
  - 4: a XOR b.
  - 5: b.
  - 6: a AND NOT b.
  - 7: NOT b.

  With the flag-update bit set, they set N and Z from the result, clear V and keep C.
- R7: Results appear one cycle after issue. `wb_en`, `wb_data` and `wb_dst` are valid after the clock edge that samples the operation. Without `issue_vld`, nothing is written and the flags are kept.
- R8: A flag update made by one operation decides the condition of an operation issued in the very next cycle.
- R9: Condition codes 8 to 15 never hold. Such operations write nothing and change no flag.
- R10: Flags set by a flag-updating operation remain in force across any number of later executed operations that have the flag-update bit clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| issue_vld | input | 1 | Operation present this cycle |
| issue_op | input | 3 | ALU opcode (R5, R6) |
| issue_a | input | DATA_W | First operand |
| issue_b | input | DATA_W | Second operand |
| issue_dst | input | REG_IDX_W | Destination register index |
| issue_cond | input | 4 | Condition code (R2, R9) |
| issue_setf | input | 1 | Flag-update enable |
| wb_en | output | 1 | Write-back enable, one cycle after issue |
| wb_data | output | DATA_W | Write-back value |
| wb_dst | output | REG_IDX_W | Write-back register index |
| flags_o | output | 4 | Current flags {N,Z,C,V} |

## Verification
The hardest situation to reach is a dependence between adjacent issues. In that case the condition of one operation is decided by a flag value that the previous operation wrote only one edge earlier. The stimulus issues a flag-setting subtract and a conditional move at consecutive clock cycles, with both passing and failing outcomes. It also sweeps all condition codes against four flag states, including the mixed carry/overflow state in which code 7 passes. It also checks that a failed condition with the flag-update bit set leaves the flags intact.

// File: rtl/pred_exec_pkg.sv
package pred_exec_pkg;
  localparam int OP_W   = 3;
  localparam int COND_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_ADD  = 3'd0,
    OP_SUB  = 3'd1,
    OP_AND  = 3'd2,
    OP_OR   = 3'd3,
    OP_XOR  = 3'd4,
    OP_MOV  = 3'd5,
    OP_ANDN = 3'd6,
    OP_MVN  = 3'd7
  } alu_op_e;

  typedef enum logic [COND_W-1:0] {
    CND_ALWAYS = 4'd0,
    CND_ZSET   = 4'd1,
    CND_ZCLR   = 4'd2,
    CND_CSET   = 4'd3,
    CND_CCLR   = 4'd4,
    CND_VSET   = 4'd5,
    CND_VCLR   = 4'd6,
    CND_CS_VC  = 4'd7
  } cond_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } flags_t;
endpackage

// File: rtl/pred_rst_sync.sv
module pred_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/pred_cond_eval.sv
module pred_cond_eval
  import pred_exec_pkg::*;
(
  input  logic [COND_W-1:0] cond,
  input  logic              z,
  input  logic              c,
  input  logic              v,
  output logic              pass
);
  always_comb begin
    case (cond_e'(cond))
      CND_ALWAYS: pass = 1'b1;
      CND_ZSET:   pass = z;
      CND_ZCLR:   pass = ~z;
      CND_CSET:   pass = c;
      CND_CCLR:   pass = ~c;
      CND_VSET:   pass = v;
      CND_VCLR:   pass = ~v;
      CND_CS_VC:  pass = c & ~v;
      default:    pass = 1'b0;   // codes 8..15: never (R9)
    endcase
  end
endmodule

// File: rtl/pred_alu.sv
module pred_alu
  import pred_exec_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [OP_W-1:0]   op,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic              carry_in,
  output logic [DATA_W-1:0] result,
  output flags_t            flags_nx
);
  localparam int MSB = DATA_W - 1;

  logic              is_sub;
  logic [DATA_W-1:0] b_eff;
  logic [DATA_W:0]   wide;

  always_comb begin
    is_sub = (alu_op_e'(op) == OP_SUB);
    b_eff  = is_sub ? ~b : b;
    wide   = {1'b0, a} + {1'b0, b_eff} + {{DATA_W{1'b0}}, is_sub};
  end

  always_comb begin
    flags_nx.c = carry_in;
    flags_nx.v = 1'b0;
    case (alu_op_e'(op))
      OP_ADD, OP_SUB: begin
        result     = wide[MSB:0];
        flags_nx.c = wide[DATA_W];
        flags_nx.v = (a[MSB] == b_eff[MSB]) && (wide[MSB] != a[MSB]);
      end
      OP_AND:  result = a & b;
      OP_OR:   result = a | b;
      OP_XOR:  result = a ^ b;
      OP_MOV:  result = b;
      OP_ANDN: result = a & ~b;
      OP_MVN:  result = ~b;
      default: result = b;
    endcase
    flags_nx.n = result[MSB];
    flags_nx.z = (result == '0);
  end
endmodule

// File: rtl/pred_flag_reg.sv
module pred_flag_reg
  import pred_exec_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   upd,
  input  flags_t flags_d,
  output flags_t flags_q
);
  flags_t flags_nx;

  always_comb begin
    flags_nx = flags_q;
    if (upd) flags_nx = flags_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= flags_nx;
  end

  // R4/R10: without an update request the stored flags persist
  a_r10_flags_persist: assert property (@(posedge clk) disable iff (!rst_n)
    !upd |=> $stable(flags_q));
  // R8: a requested update is visible after exactly one edge
  a_r8_update_next: assert property (@(posedge clk) disable iff (!rst_n)
    upd |=> (flags_q == $past(flags_d)));
endmodule

// File: rtl/pred_exec_unit.sv
module pred_exec_unit
  import pred_exec_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int REG_IDX_W = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 issue_vld,
  input  logic [OP_W-1:0]      issue_op,
  input  logic [DATA_W-1:0]    issue_a,
  input  logic [DATA_W-1:0]    issue_b,
  input  logic [REG_IDX_W-1:0] issue_dst,
  input  logic [COND_W-1:0]    issue_cond,
  input  logic                 issue_setf,
  output logic                 wb_en,
  output logic [DATA_W-1:0]    wb_data,
  output logic [REG_IDX_W-1:0] wb_dst,
  output logic [3:0]           flags_o
);
  logic              rst_sync_n;
  flags_t            flags_q;
  flags_t            alu_flags;
  logic [DATA_W-1:0] alu_res;
  logic              cond_ok;
  logic              exec;
  logic              flag_upd;

  logic                 wb_en_q,   wb_en_d;
  logic [DATA_W-1:0]    wb_data_q, wb_data_d;
  logic [REG_IDX_W-1:0] wb_dst_q,  wb_dst_d;

  pred_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  pred_cond_eval u_cond (
    .cond(issue_cond), .z(flags_q.z), .c(flags_q.c), .v(flags_q.v), .pass(cond_ok)
  );

  pred_alu #(.DATA_W(DATA_W)) u_alu (
    .op(issue_op), .a(issue_a), .b(issue_b), .carry_in(flags_q.c),
    .result(alu_res), .flags_nx(alu_flags)
  );

  always_comb begin
    exec     = issue_vld & cond_ok;
    flag_upd = exec & issue_setf;
  end

  pred_flag_reg u_flags (
    .clk(clk), .rst_n(rst_sync_n), .upd(flag_upd), .flags_d(alu_flags), .flags_q(flags_q)
  );

  // next-state for write-back register, data held unless an op executes
  always_comb begin
    wb_en_d   = exec;
    wb_data_d = wb_data_q;
    wb_dst_d  = wb_dst_q;
    if (exec) begin
      wb_data_d = alu_res;
      wb_dst_d  = issue_dst;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      wb_en_q   <= 1'b0;
      wb_data_q <= '0;
      wb_dst_q  <= '0;
    end else begin
      wb_en_q   <= wb_en_d;
      wb_data_q <= wb_data_d;
      wb_dst_q  <= wb_dst_d;
    end
  end

  assign wb_en   = wb_en_q;
  assign wb_data = wb_data_q;
  assign wb_dst  = wb_dst_q;
  assign flags_o = flags_q;

  // R3: failed condition leaves no write and no flag change
  a_r3_fail_no_write: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (issue_vld && !cond_ok) |=> !wb_en);
  a_r3_fail_flags_kept: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (issue_vld && !cond_ok) |=> $stable(flags_o));
  // R7: idle cycles write nothing
  a_r7_idle_no_write: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !issue_vld |=> (!wb_en && $stable(flags_o)));
  // R9: codes 8..15 never execute
  a_r9_never_codes: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (issue_vld && issue_cond[3]) |=> (!wb_en && $stable(flags_o)));
  // R4: executed op without flag-update bit keeps flags
  a_r4_noset_keeps: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (issue_vld && !issue_setf) |=> $stable(flags_o));
  // R7: an executed op presents its destination one cycle later
  a_r7_dst_latency: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (issue_vld && cond_ok) |=> (wb_en && wb_dst == $past(issue_dst)));
endmodule

// File: tb/test_pred_exec_unit.sv
module test_pred_exec_unit;
  localparam int DW = 32;
  localparam int RW = 4;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          issue_vld;
  logic [2:0]    issue_op;
  logic [DW-1:0] issue_a, issue_b;
  logic [RW-1:0] issue_dst;
  logic [3:0]    issue_cond;
  logic          issue_setf;
  logic          wb_en;
  logic [DW-1:0] wb_data;
  logic [RW-1:0] wb_dst;
  logic [3:0]    flags_o;

  always #5 clk = ~clk;

  pred_exec_unit #(.DATA_W(DW), .REG_IDX_W(RW)) i_pred_exec_unit (
    .clk(clk), .rst_n(rst_n), .issue_vld(issue_vld), .issue_op(issue_op),
    .issue_a(issue_a), .issue_b(issue_b), .issue_dst(issue_dst),
    .issue_cond(issue_cond), .issue_setf(issue_setf),
    .wb_en(wb_en), .wb_data(wb_data), .wb_dst(wb_dst), .flags_o(flags_o)
  );

  typedef struct packed {
    logic          en;
    logic [DW-1:0] data;
    logic [RW-1:0] dst;
    logic [3:0]    flg;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];
  int    errors = 0;
  int    checks = 0;
  logic [3:0] mf;  // bench flag model {N,Z,C,V}

  function automatic logic holds(input logic [3:0] c, input logic [3:0] f);
    case (c)
      4'd0: return 1'b1;
      4'd1: return f[2];
      4'd2: return !f[2];
      4'd3: return f[1];
      4'd4: return !f[1];
      4'd5: return f[0];
      4'd6: return !f[0];
      4'd7: return f[1] && !f[0];
      default: return 1'b0;
    endcase
  endfunction

  task automatic issue(input logic [2:0] op, input logic [DW-1:0] a, input logic [DW-1:0] b,
                       input logic [RW-1:0] dst, input logic [3:0] cond, input logic setf,
                       input string tag);
    exp_t e;
    logic [DW-1:0] r;
    logic [3:0] nf;
    logic go;
    @(negedge clk);
    issue_vld = 1'b1; issue_op = op; issue_a = a; issue_b = b;
    issue_dst = dst; issue_cond = cond; issue_setf = setf;
    nf = mf;
    case (op)
      3'd0: begin r = a + b; nf[1] = (a + b) < a; nf[0] = (a[DW-1] == b[DW-1]) && (r[DW-1] != a[DW-1]); end
      3'd1: begin r = a - b; nf[1] = (a >= b);     nf[0] = (a[DW-1] != b[DW-1]) && (r[DW-1] != a[DW-1]); end
      3'd2: begin r = a & b;  nf[0] = 1'b0; end
      3'd3: begin r = a | b;  nf[0] = 1'b0; end
      3'd4: begin r = a ^ b;  nf[0] = 1'b0; end
      3'd5: begin r = b;      nf[0] = 1'b0; end
      3'd6: begin r = a & ~b; nf[0] = 1'b0; end
      default: begin r = ~b;  nf[0] = 1'b0; end
    endcase
    nf[3] = r[DW-1];
    nf[2] = (r == '0);
    go = holds(cond, mf);
    if (go && setf) mf = nf;
    e.en = go; e.data = r; e.dst = dst; e.flg = mf;
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  task automatic idle(input logic [3:0] cond, input logic setf, input string tag);
    exp_t e;
    @(negedge clk);
    issue_vld = 1'b0; issue_op = 3'd0; issue_a = 32'd1; issue_b = 32'd1;
    issue_cond = cond; issue_setf = setf;
    e.en = 1'b0; e.data = '0; e.dst = '0; e.flg = mf;
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  // monitor: compares two time units after each rising edge
  always @(posedge clk) begin
    #2;
    if (exp_q.size() > 0) begin
      exp_t e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (wb_en !== e.en || flags_o !== e.flg ||
          (e.en && (wb_data !== e.data || wb_dst !== e.dst))) begin
        errors++;
        $display("FAIL %s: actual en=%b data=%h dst=%h flags=%b expected en=%b data=%h dst=%h flags=%b",
                 t, wb_en, wb_data, wb_dst, flags_o, e.en, e.data, e.dst, e.flg);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    mf = 4'b0000;
    issue_vld = 0; issue_op = 0; issue_a = 0; issue_b = 0;
    issue_dst = 0; issue_cond = 0; issue_setf = 0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #2;
    checks++;
    if (wb_en !== 1'b0 || flags_o !== 4'b0000) begin
      errors++;
      $display("FAIL R1 during reset: actual en=%b flags=%b expected en=0 flags=0000", wb_en, flags_o);
    end
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #2;
    checks++;
    if (wb_en !== 1'b0 || flags_o !== 4'b0000) begin
      errors++;
      $display("FAIL R1 after release: actual en=%b flags=%b expected en=0 flags=0000", wb_en, flags_o);
    end

    // R5 arithmetic
    issue(3'd0, 32'd5, 32'd7, 4'd1, 4'd0, 1'b1, "R5 add small");
    issue(3'd0, 32'hFFFF_FFFF, 32'd1, 4'd2, 4'd0, 1'b1, "R5 add carry zero");
    issue(3'd0, 32'h7FFF_FFFF, 32'd1, 4'd3, 4'd0, 1'b1, "R5 add overflow");
    issue(3'd1, 32'd5, 32'd5, 4'd4, 4'd0, 1'b1, "R5 sub equal");
    issue(3'd1, 32'd3, 32'd5, 4'd5, 4'd0, 1'b1, "R5 sub borrow");
    issue(3'd1, 32'h8000_0000, 32'd1, 4'd6, 4'd0, 1'b1, "R5 sub overflow");
    // R6 logic, carry currently 1 and must stay
    issue(3'd2, 32'h0000_F0F0, 32'h0000_FF00, 4'd7, 4'd0, 1'b1, "R6 and");
    issue(3'd3, 32'h0000_F0F0, 32'h0F00_000F, 4'd8, 4'd0, 1'b1, "R6 or");
    issue(3'd4, 32'hAAAA_AAAA, 32'hAAAA_AAAA, 4'd9, 4'd0, 1'b1, "R6 xor zero");
    issue(3'd5, 32'd0, 32'h8000_0001, 4'd10, 4'd0, 1'b1, "R6 mov");
    issue(3'd6, 32'hFFFF_0000, 32'hF0F0_F0F0, 4'd11, 4'd0, 1'b1, "R6 andn");
    issue(3'd7, 32'd0, 32'd0, 4'd12, 4'd0, 1'b1, "R6 mvn");
    issue(3'd1, 32'd3, 32'd5, 4'd1, 4'd0, 1'b1, "R5 clear carry");
    issue(3'd3, 32'd0, 32'd0, 4'd13, 4'd0, 1'b1, "R6 or keeps clear carry");

    // R2 sweep against four flag states
    issue(3'd1, 32'd4, 32'd4, 4'd0, 4'd0, 1'b1, "R2 set Z C");
    for (int c = 0; c < 8; c++) issue(3'd5, 32'd0, 32'(100 + c), 4'(c), 4'(c), 1'b0, "R2 cond Z=1 C=1 V=0");
    issue(3'd1, 32'd1, 32'd2, 4'd0, 4'd0, 1'b1, "R2 set N");
    for (int c = 0; c < 8; c++) issue(3'd5, 32'd0, 32'(200 + c), 4'(c), 4'(c), 1'b0, "R2 cond all clear");
    issue(3'd1, 32'h8000_0000, 32'd1, 4'd0, 4'd0, 1'b1, "R2 set C V");
    for (int c = 0; c < 8; c++) issue(3'd5, 32'd0, 32'(300 + c), 4'(c), 4'(c), 1'b0, "R2 cond C=1 V=1");
    issue(3'd1, 32'd5, 32'd1, 4'd0, 4'd0, 1'b1, "R2 set C only");
    for (int c = 0; c < 8; c++) issue(3'd5, 32'd0, 32'(400 + c), 4'(c), 4'(c), 1'b0, "R2 cond C=1 V=0");

    // R3 failing condition with setf
    issue(3'd0, 32'd0, 32'd0, 4'd3, 4'd1, 1'b1, "R3 fail EQ setf");
    issue(3'd1, 32'd1, 32'd2, 4'd3, 4'd4, 1'b1, "R3 fail CC setf");
    issue(3'd5, 32'd0, 32'd77, 4'd4, 4'd2, 1'b0, "R3 flags intact");
    // R4 executed without setf
    issue(3'd0, 32'hFFFF_FFFF, 32'd1, 4'd5, 4'd0, 1'b0, "R4 add no setf");
    issue(3'd7, 32'd0, 32'd0, 4'd6, 4'd0, 1'b0, "R4 mvn no setf");

    // R8 back-to-back dependence
    issue(3'd1, 32'd9, 32'd9, 4'd0, 4'd0, 1'b1, "R8 compare equal");
    issue(3'd5, 32'd0, 32'd55, 4'd7, 4'd1, 1'b0, "R8 EQ next cycle pass");
    issue(3'd1, 32'd9, 32'd8, 4'd0, 4'd0, 1'b1, "R8 compare unequal");
    issue(3'd5, 32'd0, 32'd66, 4'd8, 4'd1, 1'b0, "R8 EQ next cycle fail");

    // R9 never codes
    for (int c = 8; c < 16; c++) issue(3'd0, 32'd0, 32'd0, 4'(c), 4'(c), 1'b1, "R9 never code");

    // R10 persistence over a long run
    issue(3'd1, 32'd2, 32'd2, 4'd0, 4'd0, 1'b1, "R10 set Z");
    for (int i = 0; i < 20; i++) issue(3'(i % 8), 32'(i), 32'(i * 3 + 1), 4'(i), 4'd0, 1'b0, "R10 run");
    issue(3'd5, 32'd0, 32'd88, 4'd9, 4'd1, 1'b0, "R10 EQ after run");
    issue(3'd5, 32'd0, 32'd99, 4'd10, 4'd2, 1'b0, "R10 NE after run");

    // R7 idle cycles
    idle(4'd0, 1'b1, "R7 idle no write");
    idle(4'd0, 1'b0, "R7 idle again");
    issue(3'd0, 32'd1, 32'd2, 4'd11, 4'd0, 1'b0, "R7 latency");

    @(negedge clk); issue_vld = 1'b0;
    repeat (3) @(posedge clk);
    #3;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule